// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block drives two pulse-width outputs from one down-counter. The counter starts at a period value, steps down to zero and then restarts from that value, so one period is the period value plus one clock cycle. Each output goes high when the counter holds the period value and goes low when the counter equals that output's own threshold. A larger threshold therefore gives a shorter high time.

Software never writes the live period or threshold registers. Each write lands in a shadow copy and raises a pending flag. The live copy is replaced only at a counter-zero cycle, so a period never runs with a mix of old and new settings. A mode input selects how the shadow copies are released. In direct mode, any pending value moves over at the next zero. In gated mode, a value waits for a strobe that several generators share, and it moves over at the first zero after that strobe. A shared clear input lets several generators restart their counters together. An interrupt line collects a chosen subset of the raw counter events into sticky status bits.

Top module: `pwmgen_top`

## Requirements
- R1: The counter reloads from the live period value L when it is at zero, then counts down by one per cycle to zero, so each period lasts L+1 cycles.
- R2: Each output is registered. It is set one cycle after a cycle where the counter equals L, and it is cleared one cycle after a cycle where the counter equals its threshold C. When both happen in the same cycle, the clear wins. Over a steady period the output is high for L-C cycles when C <= L, and for all L+1 cycles when C > L. Output A uses threshold A and output B uses threshold B.
- R3: In direct mode (`sync_mode`=0), a written value is held back until the counter next reaches zero. A write in mid-period does not change the rest of that period.
- R4: In gated mode (`sync_mode`=1), a written value stays pending across any number of zeros until `glb_update` is pulsed. It then becomes live at the next zero.
- R5: A `glb_update` pulse releases only registers that are pending when the pulse arrives. A value written after the pulse waits for a later pulse. A new write to a register also cancels any earlier release for that register.
- R6: `pend` has bit 0 for the period register, bit 1 for threshold A and bit 2 for threshold B. A bit is set by a write to its register and is cleared when the value becomes live, which only happens at a counter-zero cycle.
- R7: `glb_cnt_clr` forces the counter to zero on the next edge. The counter reloads from L on the edge after that.
- R8: The status bits map to events as follows: bit 0 is counter at zero, bit 1 is counter at L, bit 2 is a threshold-A match and bit 3 is a threshold-B match. A status bit is set one cycle after its event when the matching `irq_en` bit is 1. `irq` is the OR of all status bits. Events whose enable bit is 0 do not set their status bit.
- R9: `irq_clr` clears status bits by writing a one to each bit to be cleared. A status bit that is set and cleared in the same cycle stays set.
- R10: After reset, `count`, `pwm_a`, `pwm_b`, `pend` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 0 = direct release at zero, 1 = release gated by `glb_update` |
| glb_update | input | 1 | Shared release strobe for gated mode |
| glb_cnt_clr | input | 1 | Shared synchronous counter clear |
| load_wr | input | 1 | Write strobe for the period shadow |
| load_wdata | input | CNT_W | New period value |
| cmpa_wr | input | 1 | Write strobe for the threshold A shadow |
| cmpa_wdata | input | CNT_W | New threshold A |
| cmpb_wr | input | 1 | Write strobe for the threshold B shadow |
| cmpb_wdata | input | CNT_W | New threshold B |
| irq_en | input | 4 | Per-event interrupt enables |
| irq_clr | input | 4 | Write-one-to-clear for the status bits |
| count | output | CNT_W | Current counter value |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| pend | output | 3 | Pending flags for the shadow registers |
| irq | output | 1 | Interrupt, OR of the status bits |

## Verification
A live register that changes outside a zero cycle would show up as a counter that jumps or skips, or as a duty cycle that differs from L-C, within the same period. A release gate that opens too early would show as a reload from the new period value one zero earlier than expected, visible on `count` the cycle after that zero. A `pend` bit that does not clear, or an interrupt bit that is lost or not cleared, is visible on its port one edge after the cause. For these reasons the checks sample `count`, the pulse widths, `pend` and `irq` on the cycle right after each zero and each event.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
    localparam int NUM_EV   = 4;
    localparam int EV_ZERO  = 0;
    localparam int EV_LOAD  = 1;
    localparam int EV_CMPA  = 2;
    localparam int EV_CMPB  = 3;

    localparam int NUM_REG  = 3;
    localparam int REG_LOAD = 0;
    localparam int REG_CMPA = 1;
    localparam int REG_CMPB = 2;

    localparam int NUM_CH   = 2;
endpackage

// File: rtl/pwmgen_shadow.sv
module pwmgen_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         sync_mode,
    input  logic         glb_update,
    input  logic         at_zero,
    output logic [W-1:0] active,
    output logic [W-1:0] active_nxt,
    output logic         pend,
    output logic         rel
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] active;
        logic         pend;
        logic         rel;
    } st_t;

    st_t  st_d, st_q;
    logic commit;

    always_comb begin
        st_d   = st_q;
        commit = st_q.pend && at_zero && (!sync_mode || st_q.rel);
        if (commit) begin
            st_d.active = st_q.shadow;
            st_d.pend   = 1'b0;
            st_d.rel    = 1'b0;
        end else if (glb_update && st_q.pend) begin
            st_d.rel    = 1'b1;
        end
        if (wr) begin
            st_d.shadow = wdata;
            st_d.pend   = 1'b1;
            st_d.rel    = 1'b0;
        end
        active_nxt = st_d.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign pend   = st_q.pend;
    assign rel    = st_q.rel;
endmodule

// File: rtl/pwmgen_counter.sv
module pwmgen_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         at_zero
);
    typedef struct packed {
        logic [W-1:0] count;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.count == '0);
        if (clr)          st_d.count = '0;
        else if (at_zero) st_d.count = reload;
        else              st_d.count = st_q.count - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
endmodule

// File: rtl/pwmgen_events.sv
module pwmgen_events
    import pwmgen_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [W-1:0]                  count,
    input  logic [NUM_REG-1:0][W-1:0]     act,
    output logic [NUM_EV-1:0]             ev,
    output logic [NUM_CH-1:0]             pwm
);
    typedef struct packed {
        logic [NUM_CH-1:0] pwm;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        ev[EV_ZERO] = (count == '0);
        ev[EV_LOAD] = (count == act[REG_LOAD]);
        ev[EV_CMPA] = (count == act[REG_CMPA]);
        ev[EV_CMPB] = (count == act[REG_CMPB]);
        st_d = st_q;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (ev[EV_CMPA + ch])  st_d.pwm[ch] = 1'b0;
            else if (ev[EV_LOAD])  st_d.pwm[ch] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm = st_q.pwm;
endmodule

// File: rtl/pwmgen_irq.sv
module pwmgen_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] en,
    input  logic [N-1:0] clr,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr) | (ev & en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = |st_q.stat;
endmodule

// File: rtl/pwmgen_top.sv
module pwmgen_top
    import pwmgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_mode,
    input  logic             glb_update,
    input  logic             glb_cnt_clr,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_wdata,
    input  logic             cmpa_wr,
    input  logic [CNT_W-1:0] cmpa_wdata,
    input  logic             cmpb_wr,
    input  logic [CNT_W-1:0] cmpb_wdata,
    input  logic [3:0]       irq_en,
    input  logic [3:0]       irq_clr,
    output logic [CNT_W-1:0] count,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic [2:0]       pend,
    output logic             irq
);
    logic [NUM_REG-1:0]            wr_vec;
    logic [NUM_REG-1:0][CNT_W-1:0] wdata_vec;
    logic [NUM_REG-1:0][CNT_W-1:0] act_val;
    logic [NUM_REG-1:0][CNT_W-1:0] nxt_val;
    logic [NUM_REG-1:0]            pend_vec;
    logic [NUM_REG-1:0]            rel_vec;
    logic [NUM_EV-1:0]             ev;
    logic [NUM_CH-1:0]             pwm_vec;
    logic                          at_zero;
    logic                          unused_nxt;

    assign wr_vec    = {cmpb_wr, cmpa_wr, load_wr};
    assign wdata_vec = {cmpb_wdata, cmpa_wdata, load_wdata};

    for (genvar g = 0; g < NUM_REG; g++) begin : g_shadow
        pwmgen_shadow #(.W(CNT_W)) u_shadow (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (wr_vec[g]),
            .wdata      (wdata_vec[g]),
            .sync_mode  (sync_mode),
            .glb_update (glb_update),
            .at_zero    (at_zero),
            .active     (act_val[g]),
            .active_nxt (nxt_val[g]),
            .pend       (pend_vec[g]),
            .rel        (rel_vec[g])
        );
    end

    assign unused_nxt = ^{nxt_val[REG_CMPA], nxt_val[REG_CMPB]};

    pwmgen_counter #(.W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (glb_cnt_clr),
        .reload  (nxt_val[REG_LOAD]),
        .count   (count),
        .at_zero (at_zero)
    );

    pwmgen_events #(.W(CNT_W)) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count),
        .act   (act_val),
        .ev    (ev),
        .pwm   (pwm_vec)
    );

    pwmgen_irq #(.N(NUM_EV)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .en    (irq_en),
        .clr   (irq_clr),
        .irq   (irq)
    );

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];
    assign pend  = pend_vec;
endmodule

// File: rtl/pwmgen_checker.sv
module pwmgen_checker
    import pwmgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          sync_mode,
    input logic                          glb_cnt_clr,
    input logic [3:0]                    irq_clr,
    input logic [CNT_W-1:0]              count,
    input logic                          pwm_a,
    input logic                          pwm_b,
    input logic [2:0]                    pend,
    input logic                          irq,
    input logic [NUM_REG-1:0][CNT_W-1:0] act_val,
    input logic [NUM_REG-1:0]            rel_vec,
    input logic [NUM_EV-1:0]             ev
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_cnt_clr && count != '0 |=> count == $past(count) - 1'b1); // R1

    AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_ZERO] && !glb_cnt_clr |=> count == act_val[REG_LOAD]); // R1

    AST_PWMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev[EV_LOAD] && !ev[EV_CMPA] |=> $stable(pwm_a)); // R2

    AST_PWMB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev[EV_LOAD] && !ev[EV_CMPB] |=> $stable(pwm_b)); // R2

    AST_MIDPERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        count != '0 |=> $stable(act_val)); // R3

    for (genvar g = 0; g < NUM_REG; g++) begin : g_gate
        AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            sync_mode && !rel_vec[g] |=> $stable(act_val[g])); // R4
    end

    AST_PEND_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        |($past(pend) & ~pend) |-> $past(count) == '0); // R6

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        glb_cnt_clr |=> count == '0); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && irq_clr == 4'b0 |=> irq); // R8
endmodule

bind pwmgen_top pwmgen_checker #(.CNT_W(CNT_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_mode   (sync_mode),
    .glb_cnt_clr (glb_cnt_clr),
    .irq_clr     (irq_clr),
    .count       (count),
    .pwm_a       (pwm_a),
    .pwm_b       (pwm_b),
    .pend        (pend),
    .irq         (irq),
    .act_val     (act_val),
    .rel_vec     (rel_vec),
    .ev          (ev)
);

// File: tb/pwmgen_top_bench.sv
module pwmgen_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_mode = 1'b0, glb_update = 1'b0, glb_cnt_clr = 1'b0;
    logic        load_wr = 1'b0, cmpa_wr = 1'b0, cmpb_wr = 1'b0;
    logic [15:0] load_wdata = '0, cmpa_wdata = '0, cmpb_wdata = '0;
    logic [3:0]  irq_en = '0, irq_clr = '0;
    logic [15:0] count;
    logic        pwm_a, pwm_b, irq;
    logic [2:0]  pend;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwmgen_top #(.CNT_W(16)) u_pwmgen_top (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .glb_update(glb_update),
        .glb_cnt_clr(glb_cnt_clr), .load_wr(load_wr), .load_wdata(load_wdata),
        .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata), .cmpb_wr(cmpb_wr),
        .cmpb_wdata(cmpb_wdata), .irq_en(irq_en), .irq_clr(irq_clr),
        .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b), .pend(pend), .irq(irq)
    );

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_count(input string req, input logic [15:0] v);
        for (int i = 0; i < 300; i++) begin
            if (count == v) return;
            tick();
        end
        chk(req, {16'b0, count}, {16'b0, v});
    endtask

    task automatic measure(input string req, input int l, input bit chkp,
                           input int exp_a, input int exp_b);
        int ha = 0;
        int hb = 0;
        for (int i = 0; i <= l; i++) begin
            tick();
            chk({req, " count"}, {16'b0, count}, l - i);
            ha += int'(pwm_a);
            hb += int'(pwm_b);
        end
        if (chkp) begin
            chk({req, " width A"}, ha, exp_a);
            chk({req, " width B"}, hb, exp_b);
        end
    endtask

    task automatic t_reset;
        chk("R10 count", {16'b0, count}, 0);
        chk("R10 pwm_a", {31'b0, pwm_a}, 0);
        chk("R10 pwm_b", {31'b0, pwm_b}, 0);
        chk("R10 pend", {29'b0, pend}, 0);
        chk("R10 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_period;
        load_wr = 1; load_wdata = 9;
        cmpa_wr = 1; cmpa_wdata = 3;
        cmpb_wr = 1; cmpb_wdata = 7;
        tick();
        load_wr = 0; cmpa_wr = 0; cmpb_wr = 0;
        chk("R6 pend after write", {29'b0, pend}, 3'b111);
        chk("R3 count held at zero", {16'b0, count}, 0);
        tick();
        chk("R1 reload to 9", {16'b0, count}, 9);
        chk("R6 pend cleared", {29'b0, pend}, 0);
        wait_count("R1", 0);
        measure("R1 R2 L9", 9, 1, 6, 2);
    endtask

    task automatic t_direct;
        wait_count("R3", 5);
        load_wr = 1; load_wdata = 6;
        cmpa_wr = 1; cmpa_wdata = 1;
        tick();
        load_wr = 0; cmpa_wr = 0;
        chk("R3 no jump", {16'b0, count}, 4);
        chk("R6 pend mid", {29'b0, pend}, 3'b011);
        wait_count("R3", 2);
        chk("R3 old threshold kept", {31'b0, pwm_a}, 0);
        wait_count("R3", 0);
        measure("R3 first L6", 6, 0, 0, 0);
        measure("R2 L6 C>L", 6, 1, 5, 7);
    endtask

    task automatic t_gated;
        sync_mode = 1;
        wait_count("R4", 3);
        load_wr = 1; load_wdata = 8;
        tick();
        load_wr = 0;
        chk("R6 pend gated", {29'b0, pend}, 3'b001);
        wait_count("R4", 0);
        tick();
        chk("R4 held zero 1", {16'b0, count}, 6);
        wait_count("R4", 0);
        tick();
        chk("R4 held zero 2", {16'b0, count}, 6);
        chk("R4 still pending", {29'b0, pend}, 3'b001);
        wait_count("R4", 5);
        glb_update = 1;
        tick();
        glb_update = 0;
        wait_count("R4", 0);
        tick();
        chk("R4 released", {16'b0, count}, 8);
        chk("R6 pend released", {29'b0, pend}, 0);
    endtask

    task automatic t_early_strobe;
        glb_update = 1;
        tick();
        glb_update = 0;
        cmpa_wr = 1; cmpa_wdata = 2;
        tick();
        cmpa_wr = 0;
        wait_count("R5", 0);
        tick();
        wait_count("R5", 0);
        tick();
        chk("R5 not released", {29'b0, pend}, 3'b010);
        wait_count("R5", 0);
        measure("R5 old threshold", 8, 1, 7, 1);
        glb_update = 1;
        tick();
        glb_update = 0;
        wait_count("R5", 0);
        measure("R5 first new", 8, 0, 0, 0);
        chk("R5 pend cleared", {29'b0, pend}, 0);
        measure("R5 new threshold", 8, 1, 6, 1);
    endtask

    task automatic t_clear;
        sync_mode = 0;
        wait_count("R7", 5);
        glb_cnt_clr = 1;
        tick();
        glb_cnt_clr = 0;
        chk("R7 cleared", {16'b0, count}, 0);
        tick();
        chk("R7 reload", {16'b0, count}, 8);
    endtask

    task automatic t_irq;
        irq_en = 4'b0001;
        wait_count("R8", 4);
        irq_clr = 4'hF;
        tick();
        irq_clr = 4'h0;
        chk("R8 idle", {31'b0, irq}, 0);
        wait_count("R8", 0);
        chk("R8 not yet", {31'b0, irq}, 0);
        tick();
        chk("R8 zero event", {31'b0, irq}, 1);
        irq_en = 4'b0000;
        irq_clr = 4'hF;
        tick();
        irq_clr = 4'h0;
        chk("R9 cleared", {31'b0, irq}, 0);
        wait_count("R8", 3);
        irq_en = 4'b1000;
        wait_count("R8", 0);
        tick();
        chk("R8 zero masked", {31'b0, irq}, 0);
        wait_count("R8", 7);
        chk("R8 before B match", {31'b0, irq}, 0);
        irq_clr = 4'hF;
        tick();
        chk("R9 set wins", {31'b0, irq}, 1);
        tick();
        irq_clr = 4'h0;
        chk("R9 clear", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_period();
        t_direct();
        t_gated();
        t_early_strobe();
        t_clear();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule